// File: doc/BRIEF.md
# Dual-Channel Circular Sample Buffer Engine

This block sits between a time-slot line port and a host register port. It keeps two circular word buffers in internal memory. The outbound buffer is read one word at a time toward the line. The inbound buffer is filled one word at a time from the line. Every 32-bit word carries two independent 8-bit channels in its two lowest byte lanes.

For each direction, software programs three word addresses: where the ring begins, the last word of its first half, and the last word of the ring. A current-address register can be read back at any time. When the pointer passes the half point or the last word, the block raises a pending event. Software can mask each event onto the interrupt line and clears it by writing ones. If an event fires again while its pending bit is still set, a sticky lost flag records it, so software can detect that it fell behind by a half buffer.

After reset, a fill sequencer writes all ones into both buffers. A channel that carries no data therefore sends 0xFF. The host reaches the buffer contents through a memory window in the same register port.

Top module: `slot_ring_engine`

## Requirements
- R1: After reset, every word of both buffers reads 0xFFFFFFFF once 2^AW fill cycles have elapsed. Until then no line transfer is accepted. The pointer registers reset to base 0, half point 2^AW/2-1 and last word 2^AW-1. Pending bits, lost bits and mask reset to 0.
- R2: Bit 0 of the run register at offset 0x01 enables both directions. While it is 0, tx_valid and rx_ready are low. Writing it from 0 to 1 loads both current addresses from their base registers.
- R3: tx_ch0 and tx_ch1 show bits 7:0 and 15:8 of the outbound word at the outbound current address. The pointer advances by one word on each cycle in which tx_valid and tx_ready are both high.
- R4: On each cycle in which rx_valid and rx_ready are both high, the word {16'hFFFF, rx_ch1, rx_ch0} is written at the inbound current address, and the pointer advances by one word.
- R5: A transfer at the last-word address moves the pointer back to the base address, not to the next word.
- R6: A transfer at the last-word address sets a pending bit, and so does a transfer at the half-point address. In the status register at offset 0x06: bit 0 is outbound last word, bit 1 is outbound half point, bit 2 is inbound last word, bit 3 is inbound half point.
- R7: Writing to offset 0x06 clears every pending bit (3:0) and every lost bit (7:4) that is set in the written value. An event in the same cycle wins over the clear.
- R8: Lost bit 4+n becomes 1 when event n fires while pending bit n is still set and is not being cleared in that cycle. Once set, a lost bit stays until it is cleared.
- R9: irq is high exactly when some pending bit n is set and mask bit n (offset 0x04, bits 3:0) is set.
- R10: The outbound pointer registers sit at 0x08 (base), 0x0C (half point), 0x10 (last word) and 0x14 (current, read-only). The inbound ones sit at 0x18, 0x1C, 0x20 and 0x24. Reads return the value zero-extended, one cycle after host_rd.
- R11: Host addresses with bit ADDR_W-1 set reach buffer memory. Bit ADDR_W-2 selects inbound (1) or outbound (0), and bits AW-1:0 give the word index, for both writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe, data valid next cycle |
| host_addr | input | ADDR_W | Register offset or buffer window address |
| host_wdata | input | WORD_W | Host write data |
| host_rdata | output | WORD_W | Registered host read data |
| irq | output | 1 | Masked event interrupt |
| tx_valid | output | 1 | Outbound word available |
| tx_ready | input | 1 | Line accepts the outbound word |
| tx_ch0 | output | CH_W | Outbound channel 0 byte |
| tx_ch1 | output | CH_W | Outbound channel 1 byte |
| rx_valid | input | 1 | Inbound word present |
| rx_ready | output | 1 | Engine accepts an inbound word |
| rx_ch0 | input | CH_W | Inbound channel 0 byte |
| rx_ch1 | input | CH_W | Inbound channel 1 byte |

## Verification
The outbound path runs with a ready line that stalls at random against random buffer contents in a short ring. This separates correct advance-on-handshake from advance-every-cycle, and it makes wrap-around and event timing visible within a few dozen words. The inbound path gets random channel bytes with random valid gaps, and the buffer is then read back, including words next to the ring. This shows whether lane packing is right and whether writes stay inside the programmed window. Status reads, random write-one clears and repeated end events without a clear tell the pending, lost and masked-interrupt behaviour apart. Directed reads after reset cover the fill pattern and the pointer defaults.

// File: rtl/sre_pkg.sv
// Shared constants for the circular sample buffer engine.
// Assumes byte register offsets in the low eight address bits.
package sre_pkg;
    localparam int N_DIR = 2;
    localparam int N_EV  = 4;

    localparam logic [7:0] OFF_RUN    = 8'h01;
    localparam logic [7:0] OFF_MASK   = 8'h04;
    localparam logic [7:0] OFF_STATUS = 8'h06;
    localparam logic [7:0] OFF_DIR0   = 8'h08;
    localparam logic [7:0] DIR_STRIDE = 8'h10;

    localparam logic [7:0] SUB_BASE = 8'h00;
    localparam logic [7:0] SUB_MID  = 8'h04;
    localparam logic [7:0] SUB_LAST = 8'h08;
    localparam logic [7:0] SUB_CUR  = 8'h0C;

    // Event bit positions in the status register
    localparam int EV_TX_END = 0;
    localparam int EV_TX_MID = 1;
    localparam int EV_RX_END = 2;
    localparam int EV_RX_MID = 3;

    typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

    // Offset of a pointer register for a direction
    function automatic logic [7:0] dir_off(input int d, input logic [7:0] sub);
        return OFF_DIR0 + DIR_STRIDE * 8'(d) + sub;
    endfunction
endpackage

// File: rtl/sre_ring_ptr.sv
// Circular word pointer for one direction.
// Advances one word per step, wraps from the last word to the base and
// flags transfers at the half point and the last word.
// Assumes load and step are never high together.
module sre_ring_ptr #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mid,
    input  logic [AW-1:0] last,
    output logic [AW-1:0] cur,
    output logic          hit_mid,
    output logic          hit_end
);
    // Event pulses for the word being transferred this cycle
    always_comb begin
        hit_mid = step && (cur == mid);
        hit_end = step && (cur == last);
    end

    // Pointer register: reload, wrap or increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= base;
        end else if (step) begin
            cur <= (cur == last) ? base : cur + 1'b1;
        end
    end

    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cur == last) |=> (cur == $past(base))); // R5
    AST_STEP_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cur != last) |=> (cur == $past(cur) + 1'b1)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cur)); // R3
endmodule

// File: rtl/sre_word_ram.sv
// Word buffer with one line write port, one host write port and two
// asynchronous read ports. After reset a sequencer fills every word with
// ones; during the fill the other write ports are ignored.
// Assumes the caller holds line_we low until fill_done.
module sre_word_ram #(
    parameter int AW     = 9,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              line_we,
    input  logic [AW-1:0]     line_addr,
    input  logic [WORD_W-1:0] line_wdata,
    input  logic [AW-1:0]     rd_addr_a,
    output logic [WORD_W-1:0] rd_data_a,
    input  logic [AW-1:0]     rd_addr_b,
    output logic [WORD_W-1:0] rd_data_b,
    output logic              fill_done
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW:0]       fill_idx;

    assign fill_done = fill_idx[AW];

    // Fill sequencer: one word per cycle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_idx <= '0;
        end else if (!fill_done) begin
            fill_idx <= fill_idx + 1'b1;
        end
    end

    // Storage writes: fill first, then line, then host
    always_ff @(posedge clk) begin
        if (!fill_done) begin
            mem[fill_idx[AW-1:0]] <= '1;
        end else if (line_we) begin
            mem[line_addr] <= line_wdata;
        end else if (host_we) begin
            mem[host_addr] <= host_wdata;
        end
    end

    // Asynchronous read ports
    always_comb begin
        rd_data_a = mem[rd_addr_a];
        rd_data_b = mem[rd_addr_b];
    end

    AST_FILL_BLOCKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_done |-> !line_we); // R1
    AST_FILL_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> fill_done); // R1
endmodule

// File: rtl/sre_event_ctl.sv
// Pending, lost and mask state for the buffer events.
// Pending and lost bits are cleared by writing ones; an event in the same
// cycle wins over the clear. irq is the OR of the masked pending bits.
module sre_event_ctl #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   ev,
    input  logic           clr_we,
    input  logic [2*N-1:0] clr_bits,
    input  logic           mask_we,
    input  logic [N-1:0]   mask_in,
    output logic [N-1:0]   pend,
    output logic [N-1:0]   lost,
    output logic [N-1:0]   mask,
    output logic           irq
);
    logic [N-1:0] clr_p;
    logic [N-1:0] clr_l;

    // Decode write-one-to-clear masks
    always_comb begin
        clr_p = clr_we ? clr_bits[N-1:0]   : '0;
        clr_l = clr_we ? clr_bits[2*N-1:N] : '0;
    end

    // Pending and lost state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            lost <= '0;
        end else begin
            pend <= (pend & ~clr_p) | ev;
            lost <= (lost & ~clr_l) | (ev & pend & ~clr_p);
        end
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= mask_in;
        end
    end

    // Interrupt line
    assign irq = |(pend & mask);

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((pend & $past(ev)) == $past(ev))); // R6
    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ev == '0) |=> ((pend & $past(clr_bits[N-1:0])) == '0)); // R7
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((lost & $past(lost)) == $past(lost))); // R8
    AST_LOST_FROM_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && ((ev & pend) != '0)) |=> ((lost & $past(ev & pend)) == $past(ev & pend))); // R8
endmodule

// File: rtl/slot_ring_engine.sv
// Dual-direction circular sample buffer engine.
// Moves words between a ready/valid time-slot port and two internal ring
// buffers; channel 0 rides bits 7:0, channel 1 bits 15:8. Host port holds
// run, mask, status and per-direction pointer registers plus a memory
// window. Assumes AW < WORD_W and WORD_W >= 2*CH_W.
module slot_ring_engine
    import sre_pkg::*;
#(
    parameter int AW     = 9,
    parameter int CH_W   = 8,
    parameter int WORD_W = 32,
    parameter int ADDR_W = AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [CH_W-1:0]   tx_ch0,
    output logic [CH_W-1:0]   tx_ch1,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [CH_W-1:0]   rx_ch0,
    input  logic [CH_W-1:0]   rx_ch1
);
    localparam int DEPTH  = 1 << AW;
    localparam int FILL_W = WORD_W - 2 * CH_W;

    logic              mem_sel;
    logic              buf_rx;
    logic [7:0]        off;
    logic              reg_wr;
    logic              run_q;
    logic              load_all;
    logic              tx_fill_done;
    logic              rx_fill_done;
    logic              line_ok;
    logic [AW-1:0]     base_q [N_DIR];
    logic [AW-1:0]     mid_q  [N_DIR];
    logic [AW-1:0]     last_q [N_DIR];
    logic [AW-1:0]     cur_w  [N_DIR];
    logic [N_DIR-1:0]  step;
    logic [N_DIR-1:0]  hit_mid;
    logic [N_DIR-1:0]  hit_end;
    logic [N_EV-1:0]   ev;
    logic [N_EV-1:0]   pend;
    logic [N_EV-1:0]   lost;
    logic [N_EV-1:0]   mask;
    logic [WORD_W-1:0] tx_line_word;
    logic [WORD_W-1:0] tx_host_word;
    logic [WORD_W-1:0] rx_line_word;
    logic [WORD_W-1:0] rx_host_word;
    logic [WORD_W-1:0] reg_rd;
    logic              unused_top;

    // Host address split
    always_comb begin
        mem_sel  = host_addr[ADDR_W-1];
        buf_rx   = (host_addr[ADDR_W-2] == DIR_RX);
        off      = host_addr[7:0];
        reg_wr   = host_wr && !mem_sel;
        load_all = reg_wr && (off == OFF_RUN) && host_wdata[0] && !run_q;
    end

    // Run and pointer configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            for (int d = 0; d < N_DIR; d++) begin
                base_q[d] <= '0;
                mid_q[d]  <= AW'(DEPTH / 2 - 1);
                last_q[d] <= AW'(DEPTH - 1);
            end
        end else if (reg_wr) begin
            if (off == OFF_RUN) run_q <= host_wdata[0];
            for (int d = 0; d < N_DIR; d++) begin
                if (off == dir_off(d, SUB_BASE)) base_q[d] <= host_wdata[AW-1:0];
                if (off == dir_off(d, SUB_MID))  mid_q[d]  <= host_wdata[AW-1:0];
                if (off == dir_off(d, SUB_LAST)) last_q[d] <= host_wdata[AW-1:0];
            end
        end
    end

    // Line handshakes, gated by run and by the reset fill
    always_comb begin
        line_ok  = run_q && tx_fill_done && rx_fill_done;
        tx_valid = line_ok;
        rx_ready = line_ok;
        step[0]  = tx_valid && tx_ready;
        step[1]  = rx_valid && rx_ready;
        tx_ch0   = tx_line_word[CH_W-1:0];
        tx_ch1   = tx_line_word[2*CH_W-1:CH_W];
    end

    // One ring pointer per direction
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        sre_ring_ptr #(.AW(AW)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_all),
            .step    (step[d]),
            .base    (base_q[d]),
            .mid     (mid_q[d]),
            .last    (last_q[d]),
            .cur     (cur_w[d]),
            .hit_mid (hit_mid[d]),
            .hit_end (hit_end[d])
        );
    end

    // Event vector in status bit order
    always_comb begin
        ev            = '0;
        ev[EV_TX_END] = hit_end[0];
        ev[EV_TX_MID] = hit_mid[0];
        ev[EV_RX_END] = hit_end[1];
        ev[EV_RX_MID] = hit_mid[1];
    end

    sre_word_ram #(.AW(AW), .WORD_W(WORD_W)) u_tx_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_wr && mem_sel && !buf_rx),
        .host_addr  (host_addr[AW-1:0]),
        .host_wdata (host_wdata),
        .line_we    (1'b0),
        .line_addr  (cur_w[0]),
        .line_wdata ('0),
        .rd_addr_a  (cur_w[0]),
        .rd_data_a  (tx_line_word),
        .rd_addr_b  (host_addr[AW-1:0]),
        .rd_data_b  (tx_host_word),
        .fill_done  (tx_fill_done)
    );

    sre_word_ram #(.AW(AW), .WORD_W(WORD_W)) u_rx_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_wr && mem_sel && buf_rx),
        .host_addr  (host_addr[AW-1:0]),
        .host_wdata (host_wdata),
        .line_we    (step[1]),
        .line_addr  (cur_w[1]),
        .line_wdata ({{FILL_W{1'b1}}, rx_ch1, rx_ch0}),
        .rd_addr_a  (cur_w[1]),
        .rd_data_a  (rx_line_word),
        .rd_addr_b  (host_addr[AW-1:0]),
        .rd_data_b  (rx_host_word),
        .fill_done  (rx_fill_done)
    );

    sre_event_ctl #(.N(N_EV)) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .clr_we   (reg_wr && off == OFF_STATUS),
        .clr_bits (host_wdata[2*N_EV-1:0]),
        .mask_we  (reg_wr && off == OFF_MASK),
        .mask_in  (host_wdata[N_EV-1:0]),
        .pend     (pend),
        .lost     (lost),
        .mask     (mask),
        .irq      (irq)
    );

    // Register read multiplexer
    always_comb begin
        reg_rd = '0;
        if (off == OFF_RUN)    reg_rd[0] = run_q;
        if (off == OFF_MASK)   reg_rd[N_EV-1:0] = mask;
        if (off == OFF_STATUS) reg_rd[2*N_EV-1:0] = {lost, pend};
        for (int d = 0; d < N_DIR; d++) begin
            if (off == dir_off(d, SUB_BASE)) reg_rd[AW-1:0] = base_q[d];
            if (off == dir_off(d, SUB_MID))  reg_rd[AW-1:0] = mid_q[d];
            if (off == dir_off(d, SUB_LAST)) reg_rd[AW-1:0] = last_q[d];
            if (off == dir_off(d, SUB_CUR))  reg_rd[AW-1:0] = cur_w[d];
        end
    end

    // Registered host read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            host_rdata <= mem_sel ? (buf_rx ? rx_host_word : tx_host_word) : reg_rd;
        end
    end

    assign unused_top = ^{host_wdata, host_addr, rx_line_word};

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (!tx_valid && !rx_ready)); // R2
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_all |=> (cur_w[0] == $past(base_q[0]) && cur_w[1] == $past(base_q[1]))); // R2
endmodule

// File: tb/slot_ring_engine_bench.sv
`timescale 1ns/1ps
module slot_ring_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_ch0;
    logic [7:0]  tx_ch1;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_ch0 = '0;
    logic [7:0]  rx_ch1 = '0;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] txm [512];
    logic [31:0] rxm [512];
    logic [3:0]  pend = '0;
    logic [3:0]  lost = '0;
    logic [3:0]  mask = '0;
    int tcur = 0, tbase = 4, tmid = 7, tlast = 11;
    int rcur = 0, rbase = 20, rmid = 23, rlast = 27;

    always #4 clk = ~clk;

    slot_ring_engine u_slot_ring_engine (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_ch0(tx_ch0),
        .tx_ch1(tx_ch1), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_ch0(rx_ch0), .rx_ch1(rx_ch1)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic [11:0] a, input logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [11:0] a, output logic [31:0] v);
        host_rd = 1'b1; host_addr = a;
        tick();
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    // Expected next pointer value
    function automatic int ring_next(input int c, input int b, input int l);
        return (c == l) ? b : c + 1;
    endfunction

    // Expected inbound word packing
    function automatic logic [31:0] rx_word(input logic [7:0] c1, input logic [7:0] c0);
        return {16'hFFFF, c1, c0};
    endfunction

    task automatic fire(input int b);
        if (pend[b]) lost[b] = 1'b1;
        pend[b] = 1'b1;
    endtask

    task automatic status_check();
        logic [31:0] v;
        logic [7:0]  c;
        tx_ready = 1'b0; rx_valid = 1'b0;
        host_read(12'h006, v);
        check32("R6 R8 status", v, {24'b0, lost, pend});
        check32("R9 irq", {31'b0, irq}, {31'b0, |(pend & mask)});
        if ($urandom % 2 == 1) begin
            c = 8'($urandom);
            host_write(12'h006, {24'b0, c});
            pend &= ~c[3:0];
            lost &= ~c[7:4];
            host_read(12'h006, v);
            check32("R7 clear", v, {24'b0, lost, pend});
        end
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        for (int i = 0; i < 512; i++) begin
            txm[i] = 32'hFFFF_FFFF;
            rxm[i] = 32'hFFFF_FFFF;
        end
        repeat (4) tick();
        rst_n = 1'b1;
        check32("R1 tx_valid in fill", {31'b0, tx_valid}, 32'd0);
        repeat (520) tick();

        // Reset state
        check32("R1 irq", {31'b0, irq}, 32'd0);
        host_read(12'h006, v); check32("R1 status", v, 32'd0);
        host_read(12'h004, v); check32("R1 mask", v, 32'd0);
        host_read(12'h00C, v); check32("R1 R10 half default", v, 32'd255);
        host_read(12'h010, v); check32("R1 R10 last default", v, 32'd511);
        host_read(12'h808, v); check32("R1 tx fill", v, 32'hFFFF_FFFF);
        host_read(12'hDF4, v); check32("R1 rx fill", v, 32'hFFFF_FFFF);
        check32("R2 idle tx", {31'b0, tx_valid}, 32'd0);
        check32("R2 idle rx", {31'b0, rx_ready}, 32'd0);

        // Outbound setup: random words through the memory window
        for (int i = 0; i < 16; i++) begin
            txm[i] = $urandom;
            host_write(12'h800 | 12'(i), txm[i]);
        end
        host_read(12'h805, v); check32("R11 tx window", v, txm[5]);
        host_write(12'h008, 32'(tbase));
        host_write(12'h00C, 32'(tmid));
        host_write(12'h010, 32'(tlast));
        host_read(12'h010, v); check32("R10 tx last", v, 32'(tlast));
        mask = 4'b0101;
        host_write(12'h004, {28'b0, mask});
        host_write(12'h001, 32'd1);
        tcur = tbase; rcur = 0;
        host_read(12'h014, v); check32("R2 tx load", v, 32'(tcur));

        // Outbound stream with random stalls
        for (int i = 0; i < 90; i++) begin
            if (i % 10 == 9) begin
                status_check();
            end else begin
                tx_ready = 1'($urandom % 2);
                check32("R2 tx_valid", {31'b0, tx_valid}, 32'd1);
                check32("R3 ch0", {24'b0, tx_ch0}, {24'b0, txm[tcur][7:0]});
                check32("R3 ch1", {24'b0, tx_ch1}, {24'b0, txm[tcur][15:8]});
                tick();
                if (tx_ready) begin
                    if (tcur == tmid) fire(1);
                    if (tcur == tlast) fire(0);
                    tcur = ring_next(tcur, tbase, tlast);
                end
                tx_ready = 1'b0;
            end
        end
        status_check();

        // Stop and read the pointer back
        host_write(12'h001, 32'd0);
        check32("R2 stop tx", {31'b0, tx_valid}, 32'd0);
        check32("R2 stop rx", {31'b0, rx_ready}, 32'd0);
        host_read(12'h014, v); check32("R10 R5 tx cur", v, 32'(tcur));

        // Inbound stream
        host_write(12'h018, 32'(rbase));
        host_write(12'h01C, 32'(rmid));
        host_write(12'h020, 32'(rlast));
        mask = 4'b1100;
        host_write(12'h004, {28'b0, mask});
        host_write(12'h001, 32'd1);
        tcur = tbase; rcur = rbase;
        host_read(12'h024, v); check32("R2 rx load", v, 32'(rcur));
        for (int i = 0; i < 60; i++) begin
            if (i % 10 == 9) begin
                status_check();
            end else begin
                rx_valid = 1'($urandom % 2);
                rx_ch0 = 8'($urandom);
                rx_ch1 = 8'($urandom);
                check32("R2 rx_ready", {31'b0, rx_ready}, 32'd1);
                tick();
                if (rx_valid) begin
                    rxm[rcur] = rx_word(rx_ch1, rx_ch0);
                    if (rcur == rmid) fire(3);
                    if (rcur == rlast) fire(2);
                    rcur = ring_next(rcur, rbase, rlast);
                end
                rx_valid = 1'b0;
            end
        end
        status_check();
        host_write(12'h001, 32'd0);
        host_read(12'h024, v); check32("R10 R5 rx cur", v, 32'(rcur));
        host_read(12'h014, v); check32("R3 tx held", v, 32'(tcur));
        for (int i = 16; i < 32; i++) begin
            host_read(12'hC00 | 12'(i), v);
            check32("R4 R11 rx word", v, rxm[i]);
        end

        // Host write into the inbound buffer
        host_write(12'hC40, 32'h1234_5678);
        host_read(12'hC40, v); check32("R11 rx window", v, 32'h1234_5678);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #1_000_000;
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule